// File: doc/BRIEF.md
# ECC Error Address Capture Register

This block holds the address of the most recent correctable ECC error seen on reads from a flash-like memory that is protected in 64-bit words. When the ECC decoder flags a correctable error, it raises a one-cycle strobe and presents the failing logical address. If the capture controls allow it, the block loads that address into a 32-bit read-only value. From then on the value is locked, so the first error stays visible until software reads it.

The upper bits of the value hold the failing word address. The low three bits hold a byte offset. For ordinary data accesses the offset is zero, because ECC covers a whole 64-bit word. When the access was to the ECC check bytes themselves, the offset names the failing check-byte location.

Three conditions keep the value frozen:
- a pending-lock state that only a CPU read releases;
- either of the two error status flags being set;
- a debugger read while debug mode is active, unless a suspend-ignore control is set.

A functional reset clears only the lock state. The captured value keeps its contents across reset and is undefined at power-up.

Top module: `ecc_fault_addr_latch`

## Requirements
- R1: A strobe on `err_strobe` loads the address only if `en_one_fail` or `en_zero_fail` is 1. With both at 0, the strobe leaves `cap_value` and `cap_locked` unchanged.
- R2: With `en_profile` at 1 and both event enables at 0, a strobe does not update `cap_value`.
- R3: While `stat_zero_flag` or `stat_one_flag` is 1, no strobe changes `cap_value`.
- R4: After a load, `cap_locked` stays 1 and every further strobe is ignored until a releasing CPU read.
- R5: A read (`cpu_rd`=1) while `dbg_mode`=1 and `susp_ignore`=0 leaves `cap_locked` at 1. With `dbg_mode`=0, or with `susp_ignore`=1, a read clears `cap_locked` on that edge.
- R6: `cap_value[31:3]` equals the failing address bits 31:3. `cap_value[2:0]` is the byte-offset field.
- R7: When `ecc_byte_sel`=0, the loaded `cap_value[2:0]` is 0, which gives a 64-bit aligned address.
- R8: When `ecc_byte_sel`=1, the loaded `cap_value[2:0]` equals `err_addr[2:0]`.
- R9: A permitted strobe loads on the same clock edge. `cap_value` and `cap_locked`=1 appear after that edge and not before it.
- R10: A releasing read and a strobe in the same cycle: `cap_value` shows the old value during the read, the lock is released, and the simultaneous strobe is dropped.
- R11: Reset (`rst_n`=0) clears `cap_locked` to 0 and leaves `cap_value` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low functional reset (clears the lock only) |
| err_strobe | input | 1 | One-cycle correctable-error strobe |
| err_addr | input | 32 | Failing logical address |
| ecc_byte_sel | input | 1 | 1 when the failing access targeted ECC check bytes |
| en_one_fail | input | 1 | Event enable (one-fail) |
| en_zero_fail | input | 1 | Event enable (zero-fail) |
| en_profile | input | 1 | Error-profiling enable; does not capture on its own |
| stat_zero_flag | input | 1 | Zero-error status flag; freezes the value while 1 |
| stat_one_flag | input | 1 | One-error status flag; freezes the value while 1 |
| dbg_mode | input | 1 | Debug/emulation mode |
| susp_ignore | input | 1 | Lets reads release the lock in debug mode |
| cpu_rd | input | 1 | CPU read strobe for this register |
| cap_value | output | 32 | Captured address with byte-offset field |
| cap_locked | output | 1 | 1 while a capture waits for a releasing read |

## Verification
The hardest case to reach is a strobe that lands in the same cycle as a releasing read. The lock must be open on the following edge, yet the strobe must still be lost. The bench first loads and locks a known address. It then drives `cpu_rd` and `err_strobe` together with a fresh address, checks the old value before the edge, and checks the released lock and unchanged value after it. Debug-mode reads are handled the same way: the bench holds the lock, issues reads with and without `susp_ignore`, and sends strobes between the reads to prove the value did not move. A sweep over all 64 combinations of enables, flags and access type covers gating and formatting.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
  parameter int unsigned CAP_W = 32;
  parameter int unsigned OFS_W = 3;

  typedef struct packed {
    logic one_fail;
    logic zero_fail;
    logic profile;
  } ecc_en_t;

  // Either event enable opens capture.
  function automatic logic capture_enabled(ecc_en_t en);
    return en.one_fail | en.zero_fail;
  endfunction

  // Profiling with no event enable: errors are only counted elsewhere.
  function automatic logic profile_only(ecc_en_t en);
    return en.profile & ~capture_enabled(en);
  endfunction
endpackage

// File: rtl/ecc_cap_gate.sv
module ecc_cap_gate
  import ecc_cap_pkg::*;
(
  input  logic    err_strobe,
  input  ecc_en_t en,
  input  logic    stat_zero,
  input  logic    stat_one,
  input  logic    locked,
  input  logic    cpu_rd,
  output logic    load_evt,
  output logic    prof_only_evt,
  output logic    drop_evt
);
  logic flag_hold;
  logic open_now;

  always_comb begin
    flag_hold     = stat_zero | stat_one;
    open_now      = ~flag_hold & ~locked & ~cpu_rd;
    load_evt      = err_strobe & capture_enabled(en) & open_now;
    prof_only_evt = err_strobe & profile_only(en);
    drop_evt      = err_strobe & ~load_evt;
  end
endmodule

// File: rtl/ecc_cap_lock.sv
module ecc_cap_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic load_evt,
  input  logic cpu_rd,
  input  logic dbg_mode,
  input  logic susp_ignore,
  output logic locked,
  output logic release_evt
);
  logic read_counts;
  logic locked_q;

  always_comb begin
    read_counts = ~dbg_mode | susp_ignore;
    release_evt = cpu_rd & locked_q & read_counts;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           locked_q <= 1'b0;
    else if (load_evt)    locked_q <= 1'b1;
    else if (release_evt) locked_q <= 1'b0;
  end

  assign locked = locked_q;
endmodule

// File: rtl/ecc_cap_store.sv
module ecc_cap_store #(
  parameter int unsigned CAP_W = 32,
  parameter int unsigned OFS_W = 3
) (
  input  logic             clk,
  input  logic             load_evt,
  input  logic [CAP_W-1:0] err_addr,
  input  logic             ecc_sel,
  output logic [CAP_W-1:0] cap_value
);
  localparam logic [CAP_W-1:0] ALIGN_MASK = {{(CAP_W-OFS_W){1'b1}}, {OFS_W{1'b0}}};

  logic [CAP_W-1:0] next_val;
  logic [CAP_W-1:0] cap_q;

  always_comb next_val = ecc_sel ? err_addr : (err_addr & ALIGN_MASK);

  // Deliberately no reset: contents survive the functional reset.
  always_ff @(posedge clk) begin
    if (load_evt) cap_q <= next_val;
  end

  assign cap_value = cap_q;
endmodule

// File: rtl/ecc_fault_addr_latch.sv
module ecc_fault_addr_latch
  import ecc_cap_pkg::*;
#(
  parameter int unsigned CAP_W = ecc_cap_pkg::CAP_W,
  parameter int unsigned OFS_W = ecc_cap_pkg::OFS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_strobe,
  input  logic [CAP_W-1:0] err_addr,
  input  logic             ecc_byte_sel,
  input  logic             en_one_fail,
  input  logic             en_zero_fail,
  input  logic             en_profile,
  input  logic             stat_zero_flag,
  input  logic             stat_one_flag,
  input  logic             dbg_mode,
  input  logic             susp_ignore,
  input  logic             cpu_rd,
  output logic [CAP_W-1:0] cap_value,
  output logic             cap_locked
);
  ecc_en_t en;
  logic    load_evt;
  logic    prof_only_evt;
  logic    drop_evt;
  logic    release_evt;

  always_comb begin
    en.one_fail  = en_one_fail;
    en.zero_fail = en_zero_fail;
    en.profile   = en_profile;
  end

  ecc_cap_gate u_gate (
    .err_strobe    (err_strobe),
    .en            (en),
    .stat_zero     (stat_zero_flag),
    .stat_one      (stat_one_flag),
    .locked        (cap_locked),
    .cpu_rd        (cpu_rd),
    .load_evt      (load_evt),
    .prof_only_evt (prof_only_evt),
    .drop_evt      (drop_evt)
  );

  ecc_cap_lock u_lock (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_evt    (load_evt),
    .cpu_rd      (cpu_rd),
    .dbg_mode    (dbg_mode),
    .susp_ignore (susp_ignore),
    .locked      (cap_locked),
    .release_evt (release_evt)
  );

  ecc_cap_store #(.CAP_W(CAP_W), .OFS_W(OFS_W)) u_store (
    .clk       (clk),
    .load_evt  (load_evt),
    .err_addr  (err_addr),
    .ecc_sel   (ecc_byte_sel),
    .cap_value (cap_value)
  );
endmodule

// File: rtl/ecc_cap_checker.sv
module ecc_cap_checker #(
  parameter int unsigned CAP_W = 32,
  parameter int unsigned OFS_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             err_strobe,
  input logic             ecc_byte_sel,
  input logic             en_one_fail,
  input logic             en_zero_fail,
  input logic             en_profile,
  input logic             stat_zero_flag,
  input logic             stat_one_flag,
  input logic             dbg_mode,
  input logic             susp_ignore,
  input logic             cpu_rd,
  input logic [CAP_W-1:0] cap_value,
  input logic             cap_locked,
  input logic             load_evt,
  input logic             prof_only_evt,
  input logic             drop_evt,
  input logic             release_evt
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        seen <= 1'b0;
    else if (load_evt) seen <= 1'b1;
  end

  AST_LOAD_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |-> (err_strobe && (en_one_fail || en_zero_fail))); // R1
  AST_PROFILE_ONLY_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (prof_only_evt || (en_profile && !en_one_fail && !en_zero_fail)) |-> !load_evt); // R2
  AST_FLAG_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && (stat_zero_flag || stat_one_flag)) |=> $stable(cap_value)); // R3
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_locked && !cpu_rd) |=> (cap_locked && $stable(cap_value))); // R4
  AST_DROP_KEEPS_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && drop_evt) |=> $stable(cap_value)); // R4
  AST_DEBUG_READ_KEEPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_locked && cpu_rd && dbg_mode && !susp_ignore) |=> cap_locked); // R5
  AST_READ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    release_evt |=> !cap_locked); // R5
  AST_DATA_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !ecc_byte_sel) |=> (cap_value[OFS_W-1:0] == '0)); // R7
  AST_LOAD_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> cap_locked); // R9
  AST_READ_DROPS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && err_strobe) |-> !load_evt); // R10
endmodule

bind ecc_fault_addr_latch ecc_cap_checker #(.CAP_W(CAP_W), .OFS_W(OFS_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .err_strobe     (err_strobe),
  .ecc_byte_sel   (ecc_byte_sel),
  .en_one_fail    (en_one_fail),
  .en_zero_fail   (en_zero_fail),
  .en_profile     (en_profile),
  .stat_zero_flag (stat_zero_flag),
  .stat_one_flag  (stat_one_flag),
  .dbg_mode       (dbg_mode),
  .susp_ignore    (susp_ignore),
  .cpu_rd         (cpu_rd),
  .cap_value      (cap_value),
  .cap_locked     (cap_locked),
  .load_evt       (load_evt),
  .prof_only_evt  (prof_only_evt),
  .drop_evt       (drop_evt),
  .release_evt    (release_evt)
);

// File: tb/test_ecc_fault_addr_latch.sv
`timescale 1ns/1ps
module test_ecc_fault_addr_latch;
  localparam int W = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, err_strobe, ecc_sel, en_one, en_zero, en_prof;
  logic stat_z, stat_o, dbg, susp, cpu_rd;
  logic [W-1:0] err_addr;
  logic [W-1:0] cap_value;
  logic cap_locked;

  int nvec = 0, nbad = 0;
  logic [W-1:0] exp_val;
  logic exp_lock, exp_known;

  ecc_fault_addr_latch i_ecc_fault_addr_latch (
    .clk(clk), .rst_n(rst_n), .err_strobe(err_strobe), .err_addr(err_addr),
    .ecc_byte_sel(ecc_sel), .en_one_fail(en_one), .en_zero_fail(en_zero),
    .en_profile(en_prof), .stat_zero_flag(stat_z), .stat_one_flag(stat_o),
    .dbg_mode(dbg), .susp_ignore(susp), .cpu_rd(cpu_rd),
    .cap_value(cap_value), .cap_locked(cap_locked));

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Alignment restated arithmetically: drop the remainder modulo 8.
  function automatic logic [W-1:0] expect_fmt(input logic [W-1:0] a, input logic s);
    return s ? a : a - (a % 8);
  endfunction

  // Drive one cycle from a negedge, update the model, return at the next negedge.
  task automatic step(input logic s, input logic [W-1:0] a, input logic sel,
                      input logic rd, input logic dm, input logic si);
    logic ld, rel;
    err_strobe = s; err_addr = a; ecc_sel = sel; cpu_rd = rd; dbg = dm; susp = si;
    ld  = s && (en_one || en_zero) && !stat_z && !stat_o && !exp_lock && !rd;
    rel = rd && exp_lock && (!dm || si);
    @(posedge clk); #1;
    if (ld) begin exp_val = expect_fmt(a, sel); exp_lock = 1'b1; exp_known = 1'b1; end
    else if (rel) exp_lock = 1'b0;
    err_strobe = 0; cpu_rd = 0; dbg = 0; susp = 0; ecc_sel = 0;
    @(negedge clk);
  endtask

  task automatic chk_state(input string tag);
    chk({tag, " lock"}, {31'd0, cap_locked}, {31'd0, exp_lock});
    if (exp_known) chk({tag, " value"}, cap_value, exp_val);
  endtask

  function automatic string tag_for(input int c);
    if (c[3] || c[4]) return "R3";
    if (!c[0] && !c[1]) return c[2] ? "R2" : "R1";
    return c[5] ? "R8" : "R7";
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 0; err_strobe = 0; ecc_sel = 0; en_one = 0; en_zero = 0; en_prof = 0;
    stat_z = 0; stat_o = 0; dbg = 0; susp = 0; cpu_rd = 0; err_addr = '0;
    exp_lock = 0; exp_known = 0; exp_val = '0;
    repeat (3) @(negedge clk);
    chk("R11 reset lock", {31'd0, cap_locked}, 32'd0);
    rst_n = 1;
    @(negedge clk);

    // Sweep: bit0 one-fail, bit1 zero-fail, bit2 profile, bit3/4 flags, bit5 ECC byte
    for (int c = 0; c < 64; c++) begin
      en_one = c[0]; en_zero = c[1]; en_prof = c[2]; stat_z = c[3]; stat_o = c[4];
      step(1'b1, 32'h1357_9BDD + c * 32'h0101_0123, c[5], 1'b0, 1'b0, 1'b0);
      chk_state(tag_for(c));
      stat_z = 0; stat_o = 0;
      step(1'b0, '0, 1'b0, 1'b1, 1'b0, 1'b0);
      chk_state("R5 plain read");
    end

    en_one = 1; en_zero = 0; en_prof = 0;
    // R9: nothing visible before the edge, load visible after it
    err_strobe = 1; err_addr = 32'hFFFF_FFFF; ecc_sel = 1; #1;
    chk("R9 pre-edge lock", {31'd0, cap_locked}, 32'd0);
    step(1'b1, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 1'b0);
    chk_state("R9 post-edge");
    chk("R6 upper field", {3'b0, cap_value[W-1:3]}, {3'b0, 29'h1FFF_FFFF});
    chk("R8 offset", {29'd0, cap_value[2:0]}, 32'd7);
    // R4: later strobes ignored while locked
    step(1'b1, 32'h2222_4444, 1'b0, 1'b0, 1'b0, 1'b0);
    chk_state("R4 second error");
    step(1'b1, 32'h3333_5555, 1'b1, 1'b0, 1'b0, 1'b0);
    chk_state("R4 third error");
    // R5: debug read keeps lock; strobe still ignored
    step(1'b0, '0, 1'b0, 1'b1, 1'b1, 1'b0);
    chk_state("R5 debug read");
    step(1'b1, 32'h4444_6666, 1'b0, 1'b0, 1'b0, 1'b0);
    chk_state("R5 after debug read");
    step(1'b0, '0, 1'b0, 1'b1, 1'b1, 1'b1);
    chk_state("R5 suspend-ignore read");
    step(1'b1, 32'h5555_7777, 1'b0, 1'b0, 1'b0, 1'b0);
    chk_state("R7 capture after release");
    chk("R6 aligned value", cap_value, 32'h5555_7770);
    // R10: read and strobe together
    err_strobe = 1; cpu_rd = 1; err_addr = 32'h6666_8888; #1;
    chk("R10 read returns old", cap_value, 32'h5555_7770);
    step(1'b1, 32'h6666_8888, 1'b0, 1'b1, 1'b0, 1'b0);
    chk_state("R10 strobe dropped");
    step(1'b1, 32'h7777_9999, 1'b1, 1'b0, 1'b0, 1'b0);
    chk_state("R10 later capture");
    // R11: reset clears the lock, keeps the value
    rst_n = 0; repeat (2) @(negedge clk); rst_n = 1; exp_lock = 0;
    @(negedge clk);
    chk_state("R11 after reset");
    chk("R11 value kept", cap_value, 32'h7777_9999);

    summary();
    $finish;
  end
endmodule